// File: doc/BRIEF.md
# Round-Robin Sensor Monitoring Sequencer

This block runs a repeating monitoring sweep over a fixed group of sensor channels. Once software sets the start bit, the sequencer asks an external converter for one conversion per channel, in ascending channel order, through a held request and a one-cycle done strobe. Each returned value is compared against a per-channel low limit and high limit. The sequencer then emits a result strobe with a one-hot violation pulse that a separate interrupt-status block can collect.

Results from a sweep first collect in a shadow store. They are copied into the readable reading registers in a single step after the last channel, so a reading never mixes values from two sweeps. Between sweeps the sequencer rests for a programmable number of clock cycles. The default is one second at 50 MHz, which keeps the converter quiet for most of the time. Clearing the start bit does not abort a sweep: the sweep in progress completes and commits, and the sequencer then parks.

Top module: `sensor_sweep`

## Requirements
- R1: After reset the sequencer is parked and `convReq` stays low until `ctrlWe` writes `ctrlRun`=1. The request then rises on the second clock edge after that write.
- R2: Within a sweep, `convReq` stays high and `convCh` takes the values 0, 1, …, NUM_CH-1 in order. Each value is held until a `convDone` arrives for it, and a sweep always begins at channel 0.
- R3: After the last channel's `convDone`, `convReq` is low for one commit cycle plus IDLE_CYCLES rest cycles. It rises again exactly IDLE_CYCLES+2 edges after that done.
- R4: A converted value v on channel c is a violation when v <= low limit of c, or when v >= high limit of c. Both comparisons are unsigned and include equality.
- R5: Reading registers change only once per sweep. All channels take the sweep's values together on the second edge after the last `convDone`, and in between they keep the previous sweep's values.
- R6: Writing `ctrlRun`=0 during a sweep lets that sweep finish and commit. After that, `convReq` stays low until `ctrlRun`=1 is written again.
- R7: `resultValid` pulses high for exactly one cycle, on the edge after each accepted `convDone`. `violPulse` is one-hot at bit c for a violation on channel c, and zero otherwise. Neither output is ever high without `resultValid`.
- R8: After reset every low limit is 0 and every high limit is all ones. A limit write with `limHigh`=1 sets the high limit of `limCh`, and a write with `limHigh`=0 sets its low limit.
- R9: `rdValue` combinationally shows the reading register selected by `rdCh` at any time, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control write strobe |
| ctrlRun | input | 1 | Value written to the start bit |
| limWe | input | 1 | Limit write strobe |
| limCh | input | CH_W | Channel whose limit is written |
| limHigh | input | 1 | 1 selects high limit, 0 selects low limit |
| limData | input | DATA_W | Limit value |
| rdCh | input | CH_W | Reading register select |
| rdValue | output | DATA_W | Selected reading register |
| convReq | output | 1 | Conversion request, held until done |
| convCh | output | CH_W | Channel to convert |
| convDone | input | 1 | Converter finished, data valid this cycle |
| convData | input | DATA_W | Converted value |
| resultValid | output | 1 | One-cycle strobe per finished conversion |
| violPulse | output | NUM_CH | One-hot violation flags qualified by resultValid |

## Verification
The result strobe and the violation flags are due on the first edge after the done cycle. The readings are due on the second edge after the last done, and the next request after IDLE_CYCLES+2 edges. A restart request is due two edges after the control write. The bench drives every input at a falling edge and samples at the following falling edges, half a cycle after the edge that should have moved the output. It counts falling edges to compare the rest and restart delays exactly, and it reads a reading register after the first channel of a sweep to confirm that it still holds the old value.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;   // store convData of current channel into shadow, compare
    logic commit;    // copy shadow store into reading registers
  } sweepStrobe_t;

  typedef enum logic [1:0] {
    ST_PARK   = 2'd0,
    ST_CONV   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_REST   = 2'd3
  } sweepState_t;

endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int IDLE_CYCLES = 50_000_000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TW   = $clog2(IDLE_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlWe,
  input  logic            ctrlRun,
  input  logic            convDone,
  output logic            convReq,
  output logic [CH_W-1:0] chIdx,
  output sweepStrobe_t    strobe
);

  localparam logic [CH_W-1:0] LAST_CH  = CH_W'(NUM_CH - 1);
  localparam logic [TW-1:0]   IDLE_MAX = TW'(IDLE_CYCLES - 1);

  sweepState_t state;
  logic        runBit;
  logic [TW-1:0] restCnt;
  logic        lastCh;

  assign lastCh         = (chIdx == LAST_CH);
  assign convReq        = (state == ST_CONV);
  assign strobe.capture = (state == ST_CONV) && convDone;
  assign strobe.commit  = (state == ST_COMMIT);

  // start bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit <= 1'b0;
    end else if (ctrlWe) begin
      runBit <= ctrlRun;
    end
  end

  // sequencing state machine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PARK;
      chIdx   <= '0;
      restCnt <= '0;
    end else begin
      case (state)
        ST_PARK: begin
          if (runBit) begin
            state <= ST_CONV;
            chIdx <= '0;
          end
        end
        ST_CONV: begin
          if (convDone) begin
            if (lastCh) begin
              state <= ST_COMMIT;
            end else begin
              chIdx <= chIdx + 1'b1;
            end
          end
        end
        ST_COMMIT: begin
          restCnt <= '0;
          state   <= runBit ? ST_REST : ST_PARK;
        end
        ST_REST: begin
          if (!runBit) begin
            state <= ST_PARK;
          end else if (restCnt == IDLE_MAX) begin
            state <= ST_CONV;
            chIdx <= '0;
          end else begin
            restCnt <= restCnt + 1'b1;
          end
        end
        default: state <= ST_PARK;
      endcase
    end
  end

endmodule

// File: rtl/sweep_dpath.sv
module sweep_dpath
  import sweep_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepStrobe_t      strobe,
  input  logic [CH_W-1:0]   chIdx,
  input  logic [DATA_W-1:0] convData,
  input  logic              limWe,
  input  logic [CH_W-1:0]   limCh,
  input  logic              limHigh,
  input  logic [DATA_W-1:0] limData,
  input  logic [CH_W-1:0]   rdCh,
  output logic [DATA_W-1:0] rdValue,
  output logic              resultValid,
  output logic [NUM_CH-1:0] violPulse
);

  localparam logic [CH_W:0] NUM_CH_V = (CH_W + 1)'(NUM_CH);

  logic [DATA_W-1:0] loLim   [NUM_CH];
  logic [DATA_W-1:0] hiLim   [NUM_CH];
  logic [DATA_W-1:0] shadow  [NUM_CH];
  logic [DATA_W-1:0] reading [NUM_CH];
  logic [NUM_CH-1:0] hitNext;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic selHere;
    assign selHere = strobe.capture && (chIdx == CH_W'(g));

    // inclusive window check on the incoming sample
    assign hitNext[g] = selHere &&
                        ((convData <= loLim[g]) || (convData >= hiLim[g]));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loLim[g]   <= '0;
        hiLim[g]   <= '1;
        shadow[g]  <= '0;
        reading[g] <= '0;
      end else begin
        if (limWe && (limCh == CH_W'(g))) begin
          if (limHigh) hiLim[g] <= limData;
          else         loLim[g] <= limData;
        end
        if (selHere)       shadow[g]  <= convData;
        if (strobe.commit) reading[g] <= shadow[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      violPulse   <= '0;
    end else begin
      resultValid <= strobe.capture;
      violPulse   <= hitNext;
    end
  end

  assign rdValue = ({1'b0, rdCh} < NUM_CH_V) ? reading[rdCh] : '0;

endmodule

// File: rtl/sensor_sweep.sv
module sensor_sweep
  import sweep_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int IDLE_CYCLES = 50_000_000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic              ctrlRun,
  input  logic              limWe,
  input  logic [CH_W-1:0]   limCh,
  input  logic              limHigh,
  input  logic [DATA_W-1:0] limData,
  input  logic [CH_W-1:0]   rdCh,
  output logic [DATA_W-1:0] rdValue,
  output logic              convReq,
  output logic [CH_W-1:0]   convCh,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic              resultValid,
  output logic [NUM_CH-1:0] violPulse
);

  sweepStrobe_t    strobe;
  logic [CH_W-1:0] chIdx;

  sweep_ctrl #(
    .NUM_CH      (NUM_CH),
    .IDLE_CYCLES (IDLE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlRun  (ctrlRun),
    .convDone (convDone),
    .convReq  (convReq),
    .chIdx    (chIdx),
    .strobe   (strobe)
  );

  sweep_dpath #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .chIdx       (chIdx),
    .convData    (convData),
    .limWe       (limWe),
    .limCh       (limCh),
    .limHigh     (limHigh),
    .limData     (limData),
    .rdCh        (rdCh),
    .rdValue     (rdValue),
    .resultValid (resultValid),
    .violPulse   (violPulse)
  );

  assign convCh = chIdx;

endmodule

// File: rtl/sensor_sweep_chk.sv
module sensor_sweep_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              convReq,
  input logic [CH_W-1:0]   convCh,
  input logic              convDone,
  input logic [CH_W-1:0]   rdCh,
  input logic [DATA_W-1:0] rdValue,
  input logic              resultValid,
  input logic [NUM_CH-1:0] violPulse
);

  // R2: a sweep opens at channel 0
  p_sweep_opens_ch0_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReq) |-> (convCh == '0));

  // R2: channel only advances by one while requesting
  p_channel_steps_r2: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && $past(convReq) && (convCh != $past(convCh)))
      |-> (convCh == CH_W'($past(convCh) + 1'b1)));

  // R3: request drop is followed by at least one quiet cycle
  p_quiet_after_sweep_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convReq) |=> !convReq);

  // R5: readings do not move while conversions are in flight
  p_reading_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && $past(convReq) && $stable(rdCh)) |-> $stable(rdValue));

  // R7: every accepted done produces a result strobe
  p_valid_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone) |=> resultValid);

  // R7: a result strobe only follows an accepted done
  p_valid_needs_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(convReq && convDone));

  // R7: violation flags are one-hot and qualified
  p_viol_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(violPulse));

  p_viol_qualified_r7: assert property (@(posedge clk) disable iff (!rstN)
    (violPulse != '0) |-> resultValid);

endmodule

bind sensor_sweep sensor_sweep_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .convReq     (convReq),
  .convCh      (convCh),
  .convDone    (convDone),
  .rdCh        (rdCh),
  .rdValue     (rdValue),
  .resultValid (resultValid),
  .violPulse   (violPulse)
);

// File: tb/sensor_sweep_tb.sv
`timescale 1ns/1ps
module sensor_sweep_tb;

  localparam int NCH  = 4;
  localparam int DW   = 8;
  localparam int IDLE = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctrlWe = 1'b0, ctrlRun = 1'b0;
  logic          limWe = 1'b0, limHigh = 1'b0;
  logic [1:0]    limCh = '0, rdCh = '0;
  logic [DW-1:0] limData = '0, convData = '0;
  logic          convDone = 1'b0;
  logic [DW-1:0] rdValue;
  logic          convReq, resultValid;
  logic [1:0]    convCh;
  logic [NCH-1:0] violPulse;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [DW-1:0] loM [NCH];
  logic [DW-1:0] hiM [NCH];
  logic [DW-1:0] prevR [NCH];
  logic [DW-1:0] vals [NCH];

  always #10 clk = ~clk;

  sensor_sweep #(.NUM_CH(NCH), .DATA_W(DW), .IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlRun(ctrlRun),
    .limWe(limWe), .limCh(limCh), .limHigh(limHigh), .limData(limData),
    .rdCh(rdCh), .rdValue(rdValue), .convReq(convReq), .convCh(convCh),
    .convDone(convDone), .convData(convData), .resultValid(resultValid),
    .violPulse(violPulse));

  function automatic logic isViol(int ch, logic [DW-1:0] v);
    return (v <= loM[ch]) || (v >= hiM[ch]);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctrlWrite(logic v);
    ctrlWe = 1'b1; ctrlRun = v;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic limWrite(int ch, logic high, logic [DW-1:0] d);
    limWe = 1'b1; limCh = ch[1:0]; limHigh = high; limData = d;
    @(negedge clk);
    limWe = 1'b0;
    if (high) hiM[ch] = d; else loM[ch] = d;
  endtask

  task automatic waitReq(output int n);
    n = 0;
    while (!convReq && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic serve(int ch, logic [DW-1:0] v, bit chkIdle, int expN);
    int n;
    waitReq(n);
    if (chkIdle) check("R3 idle edges before request", n, expN);
    check("R2 channel order", convCh, ch);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    check("R2 request held", convReq, 1);
    convDone = 1'b1; convData = v;
    @(negedge clk);
    convDone = 1'b0;
    check("R7 result strobe", resultValid, 1);
    check("R4 violation flags", violPulse, isViol(ch, v) ? (1 << ch) : 0);
    @(negedge clk);
    check("R7 strobe one cycle", {resultValid, violPulse}, 0);
  endtask

  task automatic checkReadings(string req, bit usePrev);
    for (int c = 0; c < NCH; c++) begin
      rdCh = c[1:0];
      #1;
      check(req, rdValue, usePrev ? prevR[c] : vals[c]);
    end
  endtask

  task automatic runCycle(bit chkIdle, int expN, bit stopMid);
    serve(0, vals[0], chkIdle, expN);
    rdCh = 2'd0;
    #1;
    check("R5 reading held mid sweep", rdValue, prevR[0]);
    if (stopMid) ctrlWrite(1'b0);
    for (int c = 1; c < NCH; c++) serve(c, vals[c], 0, 0);
    checkReadings("R5 readings committed", 0);
    for (int c = 0; c < NCH; c++) prevR[c] = vals[c];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int n;
    void'($urandom(32'h5eed));
    for (int c = 0; c < NCH; c++) begin
      loM[c] = '0; hiM[c] = '1; prevR[c] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 no request after reset", convReq, 0);
    check("R7 no strobe after reset", {resultValid, violPulse}, 0);
    checkReadings("R9 readings zero after reset", 1);

    // R1: parked without start
    repeat (40) @(negedge clk);
    check("R1 stays parked", convReq, 0);

    // R1 start, R8 default limits
    ctrlWrite(1'b1);
    vals[0] = 8'd0; vals[1] = 8'd128; vals[2] = 8'd255; vals[3] = 8'd77;
    runCycle(1, 1, 0);

    // R4 inclusive boundaries; limits written during rest
    for (int c = 0; c < NCH; c++) begin
      limWrite(c, 1'b0, 8'd10);
      limWrite(c, 1'b1, 8'd200);
    end
    vals[0] = 8'd10; vals[1] = 8'd11; vals[2] = 8'd199; vals[3] = 8'd200;
    runCycle(0, 0, 0);

    // R3 exact rest length
    vals[0] = 8'd9; vals[1] = 8'd201; vals[2] = 8'd100; vals[3] = 8'd150;
    runCycle(1, IDLE, 0);

    // R6 stop mid sweep: sweep finishes then parks
    vals[0] = 8'd55; vals[1] = 8'd66; vals[2] = 8'd5; vals[3] = 8'd250;
    runCycle(1, IDLE, 1);
    repeat (3 * IDLE) @(negedge clk);
    check("R6 parked after stop", convReq, 0);
    checkReadings("R9 readings persist while parked", 1);

    // random limits and values
    for (int c = 0; c < NCH; c++) begin
      limWrite(c, 1'b0, DW'($urandom_range(0, 100)));
      limWrite(c, 1'b1, DW'($urandom_range(150, 255)));
    end
    ctrlWrite(1'b1);
    waitReq(n);
    check("R6 restart after start write", n, 1);
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NCH; c++) vals[c] = DW'($urandom_range(0, 255));
      if (k % 2 == 1) vals[k % NCH] = loM[k % NCH];
      runCycle(0, 0, 0);
      if (k % 3 == 2) begin
        int c2;
        c2 = $urandom_range(0, NCH - 1);
        limWrite(c2, 1'b1, vals[c2]);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule